// File: doc/BRIEF.md
# Video Port Routing Mux

This block steers pixel streams from a set of video source ports to a set of sink ports. Each beat on a port carries a 16-bit data word, a valid qualifier and five line/frame markers (line start, line end, frame start, frame end and field). Every sink has its own select field, written over a small register interface, that names the source feeding it. A source may be chosen by several sinks at once; its beats are then broadcast to all of them.

Sources come in two kinds, fixed per source by a parameter. A source with flow control is held off through its ready output until every sink attached to it can take the beat, so no attached sink loses data. A source without flow control is never held off. When one of its sinks cannot take a beat, that sink keeps the beat it already holds and an error bit for that sink is set. Error bits are sticky and cleared by writing ones. A masked OR of them drives an interrupt. Software can flush the one-beat buffer of any sink path. Select changes reach the datapath only while software holds the idle input high.

Top module: `video_route_mux`

## Requirements
- R1: Select register at address d (0..NUM_DST-1) routes source s to sink d when it holds s+1. The sink then presents that source's data and markers (marker bit 0 line start, 1 line end, 2 frame start, 3 frame end, 4 field) one cycle after the source beat.
- R2: A sink whose active select is 0 holds its valid, data and markers at zero whatever the sources drive.
- R3: When several sinks select the same source, each of them receives every beat of that source with identical data and markers.
- R4: A source with flow control sees its ready low in any cycle in which an attached sink holds a beat and is not ready. That beat goes to none of its sinks and reaches all of them once ready returns.
- R5: A source without flow control always sees ready high. When it offers a beat that an attached sink cannot take, that sink keeps its held beat and the error bit for that sink is set.
- R6: The error status at address 8 holds one sticky bit per sink. Writing a one clears a bit. A new error in the same cycle as the clear leaves the bit set.
- R7: The interrupt output is high exactly when some error bit is set whose bit in the mask register at address 9 is one.
- R8: Writing a one to bit d at address 10 empties sink d's buffer at that write's clock edge. This wins over a beat arriving in the same cycle and leaves other sinks untouched.
- R9: A written select reads back at once. The datapath adopts it only on clock edges where the idle input is high.
- R10: After reset all selects, error bits and mask bits are zero, no sink is valid, the interrupt is low and all sources see ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_idle | input | 1 | Software-held idle; lets pending selects take effect |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | WD_W | Register write data |
| reg_rdata | output | WD_W | Register read data (combinational) |
| src_valid | input | NUM_SRC | Beat valid per source |
| src_ready | output | NUM_SRC | Ready (not stalled) per source |
| src_data | input | NUM_SRC*16 | Pixel data per source |
| src_mark | input | NUM_SRC*5 | Markers per source |
| dst_valid | output | NUM_DST | Beat valid per sink |
| dst_ready | input | NUM_DST | Sink can accept a beat |
| dst_data | output | NUM_DST*16 | Pixel data per sink |
| dst_mark | output | NUM_DST*5 | Markers per sink |
| irq | output | 1 | Masked error interrupt |

## Verification
Two pairs of functions can meet in one clock. A software clear of an error bit can coincide with a new overflow on the same path. A flush of a sink can coincide with a beat arriving for it. The bench provokes each pair by raising the source beat and the register write before the same edge. It then judges the result from the register readback (the error bit must stay set) and from the sink's valid (it must be low). Separately, every one of the 625 select combinations is swept, so broadcast, single routes and unrouted sinks all occur together.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
   localparam int ADDR_W  = 4;
   localparam int MARK_W  = 5;
   localparam int MAX_DST = 8;
   localparam logic [ADDR_W-1:0] ADDR_ERR   = 4'd8;
   localparam logic [ADDR_W-1:0] ADDR_MASK  = 4'd9;
   localparam logic [ADDR_W-1:0] ADDR_FLUSH = 4'd10;
endpackage

// File: rtl/vrm_cfg_regs.sv
module vrm_cfg_regs
   import vrm_pkg::*;
#(
   parameter int NUM_DST = 4,
   parameter int SEL_W   = 3,
   parameter int WD_W    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_idle,
   input  logic                     reg_we,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [WD_W-1:0]          reg_wdata,
   input  logic [NUM_DST-1:0]       err_set,
   output logic [WD_W-1:0]          reg_rdata,
   output logic [NUM_DST*SEL_W-1:0] sel_act,
   output logic [NUM_DST-1:0]       err_q,
   output logic [NUM_DST-1:0]       mask_q,
   output logic [NUM_DST-1:0]       flush_pulse,
   output logic                     irq
);
   logic [SEL_W-1:0] pend_q [NUM_DST];
   logic             wr_err, wr_mask, wr_flush;
   logic [NUM_DST-1:0] clr_bits;

   assign wr_err      = reg_we && (reg_addr == ADDR_ERR);
   assign wr_mask     = reg_we && (reg_addr == ADDR_MASK);
   assign wr_flush    = reg_we && (reg_addr == ADDR_FLUSH);
   assign clr_bits    = wr_err   ? reg_wdata[NUM_DST-1:0] : '0;
   assign flush_pulse = wr_flush ? reg_wdata[NUM_DST-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < NUM_DST; d++) pend_q[d] <= '0;
         sel_act <= '0;
         err_q   <= '0;
         mask_q  <= '0;
      end else begin
         for (int d = 0; d < NUM_DST; d++) begin
            if (reg_we && (reg_addr == ADDR_W'(d)))
               pend_q[d] <= reg_wdata[SEL_W-1:0];
            if (cfg_idle)
               sel_act[d*SEL_W +: SEL_W] <= pend_q[d];
         end
         if (wr_mask) mask_q <= reg_wdata[NUM_DST-1:0];
         // a fresh error outranks a software clear in the same cycle
         err_q <= (err_q & ~clr_bits) | err_set;
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int d = 0; d < NUM_DST; d++)
         if (reg_addr == ADDR_W'(d)) reg_rdata[SEL_W-1:0] = pend_q[d];
      if (reg_addr == ADDR_ERR)  reg_rdata[NUM_DST-1:0] = err_q;
      if (reg_addr == ADDR_MASK) reg_rdata[NUM_DST-1:0] = mask_q;
   end

   assign irq = |(err_q & mask_q);
endmodule

// File: rtl/vrm_flow_ctl.sv
module vrm_flow_ctl #(
   parameter int NUM_SRC = 4,
   parameter int NUM_DST = 4,
   parameter int DATA_W  = 16,
   parameter int MARK_W  = 5,
   parameter int SEL_W   = 3,
   parameter logic [NUM_SRC-1:0] STALL_MASK = '1
) (
   input  logic [NUM_DST*SEL_W-1:0]  sel_act,
   input  logic [NUM_SRC-1:0]        src_valid,
   input  logic [NUM_SRC*DATA_W-1:0] src_data,
   input  logic [NUM_SRC*MARK_W-1:0] src_mark,
   input  logic [NUM_DST-1:0]        load_en,
   output logic [NUM_SRC-1:0]        src_ready,
   output logic [NUM_DST-1:0]        conn,
   output logic [NUM_DST-1:0]        xfer,
   output logic [NUM_DST-1:0]        err_set,
   output logic [NUM_DST*DATA_W-1:0] lane_data,
   output logic [NUM_DST*MARK_W-1:0] lane_mark
);
   // per-source ready: capable sources AND the room of every attached lane
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (STALL_MASK[s]) begin : g_cap
         logic rdy;
         always_comb begin
            rdy = 1'b1;
            for (int d = 0; d < NUM_DST; d++)
               if (sel_act[d*SEL_W +: SEL_W] == SEL_W'(s + 1) && !load_en[d])
                  rdy = 1'b0;
         end
         assign src_ready[s] = rdy;
      end else begin : g_free
         assign src_ready[s] = 1'b1;
      end
   end

   // per-destination source pick
   always_comb begin
      conn      = '0;
      xfer      = '0;
      err_set   = '0;
      lane_data = '0;
      lane_mark = '0;
      for (int d = 0; d < NUM_DST; d++) begin
         for (int s = 0; s < NUM_SRC; s++) begin
            if (sel_act[d*SEL_W +: SEL_W] == SEL_W'(s + 1)) begin
               conn[d] = 1'b1;
               lane_data[d*DATA_W +: DATA_W] = src_data[s*DATA_W +: DATA_W];
               lane_mark[d*MARK_W +: MARK_W] = src_mark[s*MARK_W +: MARK_W];
               if (STALL_MASK[s]) begin
                  xfer[d] = src_valid[s] && src_ready[s];
               end else begin
                  xfer[d]    = src_valid[s];
                  err_set[d] = src_valid[s] && !load_en[d];
               end
            end
         end
      end
   end
endmodule

// File: rtl/vrm_dst_lane.sv
module vrm_dst_lane #(
   parameter int DATA_W = 16,
   parameter int MARK_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conn,
   input  logic              xfer,
   input  logic              flush,
   input  logic              dst_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic [MARK_W-1:0] in_mark,
   output logic              load_en,
   output logic              dst_valid,
   output logic [DATA_W-1:0] dst_data,
   output logic [MARK_W-1:0] dst_mark
);
   logic              vld_q;
   logic [DATA_W-1:0] data_q;
   logic [MARK_W-1:0] mark_q;

   assign load_en = !vld_q || dst_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         data_q <= '0;
         mark_q <= '0;
      end else if (flush || !conn) begin
         vld_q <= 1'b0;
      end else if (load_en) begin
         vld_q <= xfer;
         if (xfer) begin
            data_q <= in_data;
            mark_q <= in_mark;
         end
      end
   end

   logic show;
   assign show      = vld_q && conn;
   assign dst_valid = show;
   assign dst_data  = show ? data_q : '0;
   assign dst_mark  = show ? mark_q : '0;
endmodule

// File: rtl/video_route_mux.sv
module video_route_mux
   import vrm_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int NUM_DST = 4,
   parameter int DATA_W  = 16,
   parameter logic [NUM_SRC-1:0] STALL_MASK = 4'b0011,
   localparam int SEL_W  = $clog2(NUM_SRC + 1),
   localparam int WD_W   = (SEL_W > NUM_DST) ? SEL_W : NUM_DST
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_idle,
   input  logic                      reg_we,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [WD_W-1:0]           reg_wdata,
   output logic [WD_W-1:0]           reg_rdata,
   input  logic [NUM_SRC-1:0]        src_valid,
   output logic [NUM_SRC-1:0]        src_ready,
   input  logic [NUM_SRC*DATA_W-1:0] src_data,
   input  logic [NUM_SRC*MARK_W-1:0] src_mark,
   output logic [NUM_DST-1:0]        dst_valid,
   input  logic [NUM_DST-1:0]        dst_ready,
   output logic [NUM_DST*DATA_W-1:0] dst_data,
   output logic [NUM_DST*MARK_W-1:0] dst_mark,
   output logic                      irq
);
   if (NUM_DST < 1 || NUM_DST > MAX_DST) begin : g_bad_dst
      $error("video_route_mux: NUM_DST must lie in 1..8");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("video_route_mux: NUM_SRC must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("video_route_mux: DATA_W must be positive");
   end

   logic [NUM_DST*SEL_W-1:0]  sel_act;
   logic [NUM_DST-1:0]        err_q, mask_q, flush_pulse, err_set;
   logic [NUM_DST-1:0]        conn, xfer, load_en;
   logic [NUM_DST*DATA_W-1:0] lane_data;
   logic [NUM_DST*MARK_W-1:0] lane_mark;

   vrm_cfg_regs #(.NUM_DST(NUM_DST), .SEL_W(SEL_W), .WD_W(WD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_idle(cfg_idle),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .err_set(err_set), .reg_rdata(reg_rdata), .sel_act(sel_act),
      .err_q(err_q), .mask_q(mask_q), .flush_pulse(flush_pulse), .irq(irq)
   );

   vrm_flow_ctl #(
      .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .DATA_W(DATA_W),
      .MARK_W(MARK_W), .SEL_W(SEL_W), .STALL_MASK(STALL_MASK)
   ) u_flow (
      .sel_act(sel_act), .src_valid(src_valid), .src_data(src_data),
      .src_mark(src_mark), .load_en(load_en), .src_ready(src_ready),
      .conn(conn), .xfer(xfer), .err_set(err_set),
      .lane_data(lane_data), .lane_mark(lane_mark)
   );

   for (genvar d = 0; d < NUM_DST; d++) begin : g_lane
      vrm_dst_lane #(.DATA_W(DATA_W), .MARK_W(MARK_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .conn(conn[d]), .xfer(xfer[d]),
         .flush(flush_pulse[d]), .dst_ready(dst_ready[d]),
         .in_data(lane_data[d*DATA_W +: DATA_W]),
         .in_mark(lane_mark[d*MARK_W +: MARK_W]),
         .load_en(load_en[d]), .dst_valid(dst_valid[d]),
         .dst_data(dst_data[d*DATA_W +: DATA_W]),
         .dst_mark(dst_mark[d*MARK_W +: MARK_W])
      );
   end
endmodule

// File: rtl/vrm_checker.sv
module vrm_checker
   import vrm_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int NUM_DST = 4,
   parameter int DATA_W  = 16,
   parameter int SEL_W   = 3,
   parameter int WD_W    = 4,
   parameter logic [NUM_SRC-1:0] STALL_MASK = '1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cfg_idle,
   input logic                      reg_we,
   input logic [ADDR_W-1:0]         reg_addr,
   input logic [WD_W-1:0]           reg_wdata,
   input logic [NUM_SRC-1:0]        src_ready,
   input logic [NUM_DST-1:0]        dst_valid,
   input logic [NUM_DST-1:0]        dst_ready,
   input logic [NUM_DST*DATA_W-1:0] dst_data,
   input logic [NUM_DST*MARK_W-1:0] dst_mark,
   input logic                      irq,
   input logic [NUM_DST*SEL_W-1:0]  sel_act,
   input logic [NUM_DST-1:0]        err_q,
   input logic [NUM_DST-1:0]        mask_q
);
   for (genvar d = 0; d < NUM_DST; d++) begin : g_d
      logic flush_d, clr_d, stuck_d;
      assign flush_d = reg_we && (reg_addr == ADDR_FLUSH) && reg_wdata[d];
      assign clr_d   = reg_we && (reg_addr == ADDR_ERR) && reg_wdata[d];
      assign stuck_d = dst_valid[d] && !dst_ready[d];

      assert_unrouted_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_act[d*SEL_W +: SEL_W] == '0) |->
            (!dst_valid[d] && dst_mark[d*MARK_W +: MARK_W] == '0
             && dst_data[d*DATA_W +: DATA_W] == '0));

      assert_hold_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (stuck_d && !flush_d && !cfg_idle) |=>
            (dst_valid[d] && $stable(dst_data[d*DATA_W +: DATA_W])));

      assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
         flush_d |=> !dst_valid[d]);

      assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (err_q[d] && !clr_d) |=> err_q[d]);

      assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(err_q[d]) && mask_q[d]) |-> irq);

      for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
         if (STALL_MASK[s]) begin : g_cap
            assert_stall_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
               (sel_act[d*SEL_W +: SEL_W] == SEL_W'(s + 1) && stuck_d) |-> !src_ready[s]);
         end else begin : g_free
            assert_never_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
               (sel_act[d*SEL_W +: SEL_W] == SEL_W'(s + 1) && stuck_d) |-> src_ready[s]);
         end
      end
   end

   assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_idle |=> $stable(sel_act));
endmodule

bind video_route_mux vrm_checker #(
   .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .DATA_W(DATA_W),
   .SEL_W(SEL_W), .WD_W(WD_W), .STALL_MASK(STALL_MASK)
) u_vrm_checker (
   .clk(clk), .rst_n(rst_n), .cfg_idle(cfg_idle), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .src_ready(src_ready),
   .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
   .dst_mark(dst_mark), .irq(irq), .sel_act(sel_act),
   .err_q(err_q), .mask_q(mask_q)
);

// File: tb/video_route_mux_bench.sv
`timescale 1ns/1ps
module video_route_mux_bench;
   logic        clk = 1'b0;
   logic        rst_n, cfg_idle, reg_we;
   logic [3:0]  reg_addr, reg_wdata, reg_rdata;
   logic [3:0]  src_valid, src_ready, dst_valid, dst_ready;
   logic [63:0] src_data, dst_data;
   logic [19:0] src_mark, dst_mark;
   logic        irq;
   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   video_route_mux u_video_route_mux (
      .clk(clk), .rst_n(rst_n), .cfg_idle(cfg_idle), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .src_mark(src_mark), .dst_valid(dst_valid), .dst_ready(dst_ready),
      .dst_data(dst_data), .dst_mark(dst_mark), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [3:0] v);
      reg_we = 1'b1; reg_addr = a; reg_wdata = v;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [3:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   function automatic logic [15:0] dval(input int s, input int c);
      return 16'((s + 1) << 12) | 16'(c);
   endfunction

   function automatic logic [4:0] mval(input int s);
      return 5'(s * 7 + 3);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int sel [4];
      int t;
      bit shared;
      string tag;
      logic [3:0] rv;
      rst_n = 1'b0; cfg_idle = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      src_valid = '0; src_data = '0; src_mark = '0; dst_ready = 4'hF;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R10 reset state
      chk("R10 dst_valid", 32'(dst_valid), 0);
      chk("R10 irq", 32'(irq), 0);
      chk("R10 src_ready", 32'(src_ready), 32'hF);
      for (int a = 0; a < 4; a++) begin
         rd(4'(a), rv); chk("R10 select", 32'(rv), 0);
      end
      rd(4'd8, rv); chk("R10 err", 32'(rv), 0);
      rd(4'd9, rv); chk("R10 mask", 32'(rv), 0);

      // exhaustive select sweep: R1 single route, R2 unrouted, R3 broadcast
      for (int c = 0; c < 625; c++) begin
         t = c;
         for (int d = 0; d < 4; d++) begin sel[d] = t % 5; t = t / 5; end
         for (int d = 0; d < 4; d++) wr(4'(d), 4'(sel[d]));
         tick();
         for (int s = 0; s < 4; s++) begin
            src_data[s*16 +: 16] = dval(s, c);
            src_mark[s*5 +: 5]   = mval(s);
         end
         src_valid = 4'hF;
         #1;
         chk("R4 ready with room", 32'(src_ready), 32'hF);
         tick();
         for (int d = 0; d < 4; d++) begin
            shared = 1'b0;
            for (int e = 0; e < 4; e++)
               if (e != d && sel[e] == sel[d] && sel[d] != 0) shared = 1'b1;
            tag = (sel[d] == 0) ? "R2 unrouted" : (shared ? "R3 broadcast" : "R1 route");
            chk(tag, 32'(dst_valid[d]), (sel[d] != 0) ? 1 : 0);
            chk(tag, 32'(dst_data[d*16 +: 16]), (sel[d] != 0) ? 32'(dval(sel[d] - 1, c)) : 0);
            chk(tag, 32'(dst_mark[d*5 +: 5]), (sel[d] != 0) ? 32'(mval(sel[d] - 1)) : 0);
         end
         src_valid = '0;
         tick();
         chk("R1 drain", 32'(dst_valid), 0);
      end
      for (int d = 0; d < 4; d++) wr(4'(d), 4'd0);
      tick();

      // R9 select held back while not idle
      cfg_idle = 1'b0;
      wr(4'd0, 4'd1);
      rd(4'd0, rv); chk("R9 readback", 32'(rv), 1);
      tick();
      src_valid[0] = 1'b1; src_data[15:0] = 16'hBEEF;
      tick();
      chk("R9 not adopted", 32'(dst_valid[0]), 0);
      src_valid = '0;
      cfg_idle = 1'b1;
      tick();
      src_valid[0] = 1'b1;
      tick();
      chk("R9 adopted valid", 32'(dst_valid[0]), 1);
      chk("R9 adopted data", 32'(dst_data[15:0]), 32'hBEEF);
      src_valid = '0;
      tick();

      // R4 broadcast stall from a flow-controlled source
      wr(4'd1, 4'd1);
      tick();
      dst_ready = 4'b1101;
      src_valid[0] = 1'b1; src_data[15:0] = 16'h1111;
      #1; chk("R4 ready both empty", 32'(src_ready[0]), 1);
      tick();
      chk("R3 both loaded", 32'(dst_valid[1:0]), 32'h3);
      chk("R3 copy data", 32'(dst_data[31:16]), 32'h1111);
      src_data[15:0] = 16'h2222;
      #1; chk("R4 stalled", 32'(src_ready[0]), 0);
      tick();
      chk("R4 no partial delivery", 32'(dst_valid[0]), 0);
      chk("R4 held beat", 32'(dst_data[31:16]), 32'h1111);
      dst_ready = 4'hF;
      #1; chk("R4 released", 32'(src_ready[0]), 1);
      tick();
      chk("R4 delivered dst0", 32'(dst_data[15:0]), 32'h2222);
      chk("R4 delivered dst1", 32'(dst_data[31:16]), 32'h2222);
      src_valid = '0;
      wr(4'd0, 4'd0); wr(4'd1, 4'd0);
      tick();

      // R5 / R6 / R7 overflow from a source without flow control
      wr(4'd2, 4'd3); wr(4'd9, 4'b0100);
      tick();
      dst_ready = 4'h0;
      src_valid[2] = 1'b1; src_data[47:32] = 16'h3333;
      #1; chk("R5 ready high", 32'(src_ready[2]), 1);
      tick();
      chk("R5 first beat", 32'(dst_data[47:32]), 32'h3333);
      src_data[47:32] = 16'h4444;
      #1; chk("R5 ready while blocked", 32'(src_ready[2]), 1);
      tick();
      rd(4'd8, rv); chk("R5 error bit", 32'(rv), 32'h4);
      chk("R7 irq raised", 32'(irq), 1);
      chk("R5 beat kept", 32'(dst_data[47:32]), 32'h3333);
      src_valid = '0;
      tick();
      rd(4'd8, rv); chk("R6 sticky", 32'(rv), 32'h4);
      wr(4'd9, 4'd0);
      chk("R7 masked", 32'(irq), 0);
      wr(4'd8, 4'd4);
      rd(4'd8, rv); chk("R6 w1c", 32'(rv), 0);
      src_valid[2] = 1'b1;
      wr(4'd8, 4'd4);
      rd(4'd8, rv); chk("R6 set beats clear", 32'(rv), 32'h4);
      src_valid = '0;
      wr(4'd8, 4'd4);
      rd(4'd8, rv); chk("R6 cleared", 32'(rv), 0);

      // R8 flush
      wr(4'd3, 4'd1);
      tick();
      src_valid[0] = 1'b1; src_data[15:0] = 16'h5555;
      tick();
      chk("R8 loaded", 32'(dst_data[63:48]), 32'h5555);
      src_valid = '0;
      wr(4'd10, 4'b1000);
      chk("R8 flushed", 32'(dst_valid[3]), 0);
      chk("R8 other lane kept", 32'(dst_valid[2]), 1);
      src_valid[0] = 1'b1; src_data[15:0] = 16'h6666;
      wr(4'd10, 4'b1000);
      chk("R8 flush beats beat", 32'(dst_valid[3]), 0);
      src_valid = '0;
      tick();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule